// File: doc/BRIEF.md
# Predicated vector element loop sequencer

This block walks through the element slots of one vectorised scalar operation. The loop is two levels deep: an outer group index `i` runs from 0 to the vector length minus one, and an inner sub-element index `s` runs from 0 to the group size minus one. Each step puts out a flat element index `i*GROUP+s` and a strobe that says whether to write a result or to write zero. The execution unit answers in the same cycle with a trap flag and a zero-result flag for the element that was issued. The block uses these answers to stop the loop early when an element traps or, in fail-first mode, when the loop must be cut short.

The loop position lives in a 32-bit state word. Software can load this word while the sequencer is idle and can always read it. The word holds the maximum length, the current length, the group size and the current outer and inner offsets. Every step writes the offsets back into the word. An ordinary trap therefore leaves the word pointing at the element that trapped, and the next start resumes there. A normal finish or a fail-first stop clears the offsets. A fail-first stop also writes the shortened length back into the word. The group size is never changed.

The controller is a four-state machine. ST_IDLE waits for `start`. ST_RUN issues one step per cycle. ST_FIN gives a one-cycle `done` and then returns to ST_IDLE. ST_HALT gives a one-cycle `trap_out` and then returns to ST_IDLE. The transitions are:
- ST_IDLE to ST_RUN on `start`.
- ST_RUN to ST_FIN when the last step finishes or on a fail-first cut.
- ST_RUN to ST_HALT when a trap is taken normally.
- ST_FIN and ST_HALT go back to ST_IDLE unconditionally.

Top module: `svseq_top`

## Requirements
- R1: After reset the state word reads 0x0000003F. That is maxlen code 63 with every other field zero. `busy`, `el_valid`, `done` and `trap_out` are all low.
- R2: The state word layout is:
  - bits 5:0: maxlen code.
  - bits 11:6: length code. Both codes are the length minus one.
  - bits 17:12: source group offset.
  - bits 23:18: destination group offset.
  - bits 25:24: group size minus one.
  - bits 27:26: source sub-offset.
  - bits 29:28: destination sub-offset.
  - bits 31:30: read as zero.

  A `cfg_wr` in ST_IDLE loads the word with these rules:
  - A length code above the maxlen code is clamped to the maxlen code.
  - The destination offsets are loaded from the source offset fields.
  - A `cfg_wr` outside ST_IDLE is ignored.
- R3: Issued elements come out in strictly rising order of `i*GROUP+s`. A group starts from the saved offsets and, after that, from `s`=0. `dst_el` always equals `src_el`.
- R4: Predicate bit `i` of `pred_mask`, latched at `start`, applies to every element of group `i`. An element of an active group raises `el_valid` and `el_wen`. Feedback is taken only from an element with `el_wen` high.
- R5: With `zeroing` set, each element of a masked-out group is issued with `el_zwr` high and `el_wen` low.
- R6: With `zeroing` clear, a masked-out group raises no strobe and uses exactly one cycle.
- R7: After the last element, `done` pulses for one cycle. `done_len` equals the full length and `cut` is low. The offsets are cleared and the length is unchanged.
- R8: A trap is taken normally when fail-first is off, or when the trap is in group 0. A normal trap pulses `trap_out` with no `done`. The state offsets keep the `i` and `s` of the trapping element, and the next `start` resumes at that element.
- R9: With fail-first on, a trap in group `i`>0 stops the loop with no further element issued. `done` and `cut` pulse, `done_len`=`i`, the length code becomes `i`-1 and the group size is unchanged.
- R10: With fail-first on and `ff_test` set, the first active element with `res_zero` high stops the loop. Its whole group is excluded: `done_len`=`i` and the length code becomes max(`i`,1)-1.
- R11: Masked-out groups before the stopping group count toward the shortened length.
- R12: `el_wen` and `el_zwr` are never high together. The length code never exceeds the maxlen code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load the state word (honoured in ST_IDLE only) |
| cfg_wdata | input | 32 | State word value to load |
| state_q | output | 32 | Current state word |
| start | input | 1 | Begin or resume an operation (ST_IDLE only) |
| pred_mask | input | 64 | Group predicate, inversion already applied |
| zeroing | input | 1 | Write zero into masked-out elements |
| ffirst | input | 1 | Fail-first mode enable |
| ff_test | input | 1 | Fail-first also stops on a zero result |
| res_trap | input | 1 | Issued element traps (same cycle) |
| res_zero | input | 1 | Issued element result is zero (same cycle) |
| busy | output | 1 | Not in ST_IDLE |
| el_valid | output | 1 | An element is issued this cycle |
| el_wen | output | 1 | Write the element result |
| el_zwr | output | 1 | Write zero to the element |
| src_el | output | 8 | Source element index |
| dst_el | output | 8 | Destination element index |
| done | output | 1 | Operation finished or cut (one cycle) |
| trap_out | output | 1 | Trap taken normally (one cycle) |
| cut | output | 1 | With `done`: the length was shortened |
| done_len | output | 7 | Group count reached, valid with `done` |

## Verification
The loop position lives only in the state word offsets. A wrong step shows up in the very next issued cycle as a missing, repeated or out-of-order `src_el`, or as a strobe of the wrong kind. A wrong decision between stop, trap and continue shows up in the cycle after the deciding element. It appears as an extra element, an early or missing `done` or `trap_out`, or a wrong `done_len`. A wrong write-back of the offsets or the length is visible on `state_q` one cycle after `done` or `trap_out` at the latest. It is also visible as the first index issued by the next resumed start.

// File: rtl/svseq_pkg.sv
package svseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2,
        ST_HALT = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic zeroing;
        logic ffirst;
        logic test;
    } seq_mode_t;

endpackage

// File: rtl/svseq_state_reg.sv
module svseq_state_reg #(
    parameter int OFF_W   = 6,
    parameter int SV_W    = 2,
    parameter int STATE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [STATE_W-1:0] cfg_wdata,
    input  logic               pos_wr,
    input  logic [OFF_W-1:0]   pos_i,
    input  logic [SV_W-1:0]    pos_s,
    input  logic               vl_wr,
    input  logic [OFF_W-1:0]   vl_new,
    output logic [OFF_W-1:0]   maxvl_o,
    output logic [OFF_W-1:0]   vl_o,
    output logic [SV_W-1:0]    subvl_o,
    output logic [OFF_W-1:0]   src_i_o,
    output logic [SV_W-1:0]    src_s_o,
    output logic [OFF_W-1:0]   dst_i_o,
    output logic [SV_W-1:0]    dst_s_o,
    output logic [STATE_W-1:0] word_o
);
    localparam int P_VL  = OFF_W;
    localparam int P_SRC = 2 * OFF_W;
    localparam int P_DST = 3 * OFF_W;
    localparam int P_SV  = 4 * OFF_W;
    localparam int P_SSV = 4 * OFF_W + SV_W;
    localparam int P_DSV = 4 * OFF_W + 2 * SV_W;

    logic [OFF_W-1:0] maxvl_q, vl_q, src_q, dst_q;
    logic [SV_W-1:0]  sv_q, ssv_q, dsv_q;

    logic [OFF_W-1:0] w_max, w_vl, w_src, w_vl_clamped;
    logic [SV_W-1:0]  w_sv, w_ssv;

    always_comb begin
        w_max        = cfg_wdata[0 +: OFF_W];
        w_vl         = cfg_wdata[P_VL +: OFF_W];
        w_src        = cfg_wdata[P_SRC +: OFF_W];
        w_sv         = cfg_wdata[P_SV +: SV_W];
        w_ssv        = cfg_wdata[P_SSV +: SV_W];
        w_vl_clamped = (w_vl > w_max) ? w_max : w_vl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            maxvl_q <= '1;
            vl_q    <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            sv_q    <= '0;
            ssv_q   <= '0;
            dsv_q   <= '0;
        end else if (cfg_wr) begin
            maxvl_q <= w_max;
            vl_q    <= w_vl_clamped;
            src_q   <= w_src;
            dst_q   <= w_src;
            sv_q    <= w_sv;
            ssv_q   <= w_ssv;
            dsv_q   <= w_ssv;
        end else begin
            if (pos_wr) begin
                src_q <= pos_i;
                dst_q <= pos_i;
                ssv_q <= pos_s;
                dsv_q <= pos_s;
            end
            if (vl_wr) begin
                vl_q <= (vl_new > maxvl_q) ? maxvl_q : vl_new;
            end
        end
    end

    always_comb begin
        word_o                 = '0;
        word_o[0 +: OFF_W]     = maxvl_q;
        word_o[P_VL +: OFF_W]  = vl_q;
        word_o[P_SRC +: OFF_W] = src_q;
        word_o[P_DST +: OFF_W] = dst_q;
        word_o[P_SV +: SV_W]   = sv_q;
        word_o[P_SSV +: SV_W]  = ssv_q;
        word_o[P_DSV +: SV_W]  = dsv_q;
    end

    assign maxvl_o = maxvl_q;
    assign vl_o    = vl_q;
    assign subvl_o = sv_q;
    assign src_i_o = src_q;
    assign src_s_o = ssv_q;
    assign dst_i_o = dst_q;
    assign dst_s_o = dsv_q;

endmodule

// File: rtl/svseq_pred_sel.sv
module svseq_pred_sel #(
    parameter int OFF_W = 6,
    parameter int XLEN  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [XLEN-1:0]  mask_in,
    input  logic [OFF_W-1:0] sel_i,
    output logic             bit_o
);
    logic [XLEN-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (load) begin
            mask_q <= mask_in;
        end
    end

    assign bit_o = mask_q[sel_i];

endmodule

// File: rtl/svseq_index.sv
module svseq_index #(
    parameter int OFF_W = 6,
    parameter int SV_W  = 2,
    parameter int EL_W  = OFF_W + SV_W
) (
    input  logic [OFF_W-1:0] grp_i,
    input  logic [SV_W-1:0]  sv_enc,
    input  logic [SV_W-1:0]  sub_s,
    output logic [EL_W-1:0]  idx_o
);
    // i*(sv_enc+1)+s = i + s + sum over set bits k of sv_enc of (i<<k)
    logic [EL_W-1:0] part [SV_W];

    for (genvar k = 0; k < SV_W; k++) begin : g_part
        assign part[k] = sv_enc[k] ? (EL_W'(grp_i) << k) : '0;
    end

    always_comb begin
        idx_o = EL_W'(grp_i) + EL_W'(sub_s);
        for (int k = 0; k < SV_W; k++) begin
            idx_o = idx_o + part[k];
        end
    end

endmodule

// File: rtl/svseq_fsm.sv
module svseq_fsm
    import svseq_pkg::*;
#(
    parameter int OFF_W = 6,
    parameter int SV_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             zeroing,
    input  logic             ffirst,
    input  logic             ff_test,
    input  logic             active,
    input  logic             res_trap,
    input  logic             res_zero,
    input  logic [OFF_W-1:0] cur_i,
    input  logic [SV_W-1:0]  cur_s,
    input  logic [OFF_W-1:0] vl,
    input  logic [SV_W-1:0]  subvl,
    output logic             idle,
    output logic             busy,
    output logic             mask_load,
    output logic             el_valid,
    output logic             el_wen,
    output logic             el_zwr,
    output logic             pos_wr,
    output logic [OFF_W-1:0] pos_i,
    output logic [SV_W-1:0]  pos_s,
    output logic             vl_wr,
    output logic [OFF_W-1:0] vl_new,
    output logic             done,
    output logic             trap_out,
    output logic             cut,
    output logic [OFF_W:0]   done_len
);
    localparam logic [OFF_W:0] ONE_L = (OFF_W+1)'(1);

    seq_state_e st_q, st_nxt;
    seq_mode_t  mode_q;
    logic       cut_q;
    logic [OFF_W:0] len_q;

    logic do_cut, do_complete;
    logic [OFF_W:0] fin_len;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            mode_q <= '0;
            cut_q  <= 1'b0;
            len_q  <= '0;
        end else begin
            st_q <= st_nxt;
            if (st_q == ST_IDLE && start) begin
                mode_q <= '{zeroing: zeroing, ffirst: ffirst, test: ff_test};
            end
            if (do_cut || do_complete) begin
                cut_q <= do_cut;
                len_q <= fin_len;
            end
        end
    end

    // next state and loop position update
    always_comb begin
        st_nxt      = st_q;
        do_cut      = 1'b0;
        do_complete = 1'b0;
        pos_wr      = 1'b0;
        pos_i       = cur_i;
        pos_s       = cur_s;
        vl_wr       = 1'b0;
        vl_new      = vl;
        fin_len     = len_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start) st_nxt = ST_RUN;
            end
            ST_RUN: begin
                if (active && res_trap) begin
                    if (mode_q.ffirst && cur_i != '0) do_cut = 1'b1;
                    else st_nxt = ST_HALT;
                end else if (active && mode_q.ffirst && mode_q.test && res_zero) begin
                    do_cut = 1'b1;
                end else if ((!active && !mode_q.zeroing) || cur_s >= subvl) begin
                    if (cur_i >= vl) begin
                        do_complete = 1'b1;
                    end else begin
                        pos_wr = 1'b1;
                        pos_i  = cur_i + 1'b1;
                        pos_s  = '0;
                    end
                end else begin
                    pos_wr = 1'b1;
                    pos_s  = cur_s + 1'b1;
                end
            end
            ST_FIN:  st_nxt = ST_IDLE;
            ST_HALT: st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase

        if (do_cut || do_complete) begin
            st_nxt = ST_FIN;
            pos_wr = 1'b1;
            pos_i  = '0;
            pos_s  = '0;
        end
        if (do_cut) begin
            vl_wr   = 1'b1;
            vl_new  = (cur_i == '0) ? '0 : cur_i - 1'b1;
            fin_len = (OFF_W+1)'(cur_i);
        end
        if (do_complete) begin
            fin_len = (OFF_W+1)'(vl) + ONE_L;
        end
    end

    // outputs
    always_comb begin
        idle      = (st_q == ST_IDLE);
        busy      = !idle;
        mask_load = idle && start;
        el_wen    = (st_q == ST_RUN) && active;
        el_zwr    = (st_q == ST_RUN) && !active && mode_q.zeroing;
        el_valid  = el_wen || el_zwr;
        done      = (st_q == ST_FIN);
        trap_out  = (st_q == ST_HALT);
        cut       = done && cut_q;
        done_len  = len_q;
    end

endmodule

// File: rtl/svseq_top.sv
module svseq_top #(
    parameter int OFF_W   = 6,
    parameter int SV_W    = 2,
    parameter int STATE_W = 32,
    localparam int XLEN   = 1 << OFF_W,
    localparam int EL_W   = OFF_W + SV_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [STATE_W-1:0] cfg_wdata,
    output logic [STATE_W-1:0] state_q,
    input  logic               start,
    input  logic [XLEN-1:0]    pred_mask,
    input  logic               zeroing,
    input  logic               ffirst,
    input  logic               ff_test,
    input  logic               res_trap,
    input  logic               res_zero,
    output logic               busy,
    output logic               el_valid,
    output logic               el_wen,
    output logic               el_zwr,
    output logic [EL_W-1:0]    src_el,
    output logic [EL_W-1:0]    dst_el,
    output logic               done,
    output logic               trap_out,
    output logic               cut,
    output logic [OFF_W:0]     done_len
);
    logic             idle, mask_load, active;
    logic             pos_wr, vl_wr;
    logic [OFF_W-1:0] pos_i, vl_new;
    logic [SV_W-1:0]  pos_s;
    logic [OFF_W-1:0] maxvl, vl, src_i, dst_i;
    logic [SV_W-1:0]  subvl, src_s, dst_s;

    svseq_state_reg #(.OFF_W(OFF_W), .SV_W(SV_W), .STATE_W(STATE_W)) u_state (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr && idle), .cfg_wdata(cfg_wdata),
        .pos_wr(pos_wr), .pos_i(pos_i), .pos_s(pos_s),
        .vl_wr(vl_wr), .vl_new(vl_new),
        .maxvl_o(maxvl), .vl_o(vl), .subvl_o(subvl),
        .src_i_o(src_i), .src_s_o(src_s), .dst_i_o(dst_i), .dst_s_o(dst_s),
        .word_o(state_q)
    );

    svseq_pred_sel #(.OFF_W(OFF_W), .XLEN(XLEN)) u_pred (
        .clk(clk), .rst_n(rst_n), .load(mask_load), .mask_in(pred_mask),
        .sel_i(src_i), .bit_o(active)
    );

    svseq_index #(.OFF_W(OFF_W), .SV_W(SV_W), .EL_W(EL_W)) u_src_idx (
        .grp_i(src_i), .sv_enc(subvl), .sub_s(src_s), .idx_o(src_el)
    );

    svseq_index #(.OFF_W(OFF_W), .SV_W(SV_W), .EL_W(EL_W)) u_dst_idx (
        .grp_i(dst_i), .sv_enc(subvl), .sub_s(dst_s), .idx_o(dst_el)
    );

    svseq_fsm #(.OFF_W(OFF_W), .SV_W(SV_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .zeroing(zeroing), .ffirst(ffirst), .ff_test(ff_test),
        .active(active), .res_trap(res_trap), .res_zero(res_zero),
        .cur_i(src_i), .cur_s(src_s), .vl(vl), .subvl(subvl),
        .idle(idle), .busy(busy), .mask_load(mask_load),
        .el_valid(el_valid), .el_wen(el_wen), .el_zwr(el_zwr),
        .pos_wr(pos_wr), .pos_i(pos_i), .pos_s(pos_s),
        .vl_wr(vl_wr), .vl_new(vl_new),
        .done(done), .trap_out(trap_out), .cut(cut), .done_len(done_len)
    );

    logic unused_maxvl;
    assign unused_maxvl = ^maxvl;

endmodule

// File: rtl/svseq_chk.sv
module svseq_chk #(
    parameter int OFF_W   = 6,
    parameter int SV_W    = 2,
    parameter int STATE_W = 32,
    parameter int EL_W    = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [STATE_W-1:0] state_q,
    input logic               busy,
    input logic               el_valid,
    input logic               el_wen,
    input logic               el_zwr,
    input logic [EL_W-1:0]    src_el,
    input logic [EL_W-1:0]    dst_el,
    input logic               done,
    input logic               trap_out
);
    // R12
    wen_zwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(el_wen && el_zwr));

    // R12
    vl_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q[OFF_W +: OFF_W] <= state_q[0 +: OFF_W]);

    // R3
    idx_rising_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (el_valid && $past(el_valid)) |-> (src_el > $past(src_el)));

    // R3
    dst_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        el_valid |-> (dst_el == src_el));

    // R7
    fin_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state_q[2*OFF_W +: OFF_W] == '0 && state_q[4*OFF_W+SV_W +: SV_W] == '0));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R8
    trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_out |-> (!done && !el_valid));

endmodule

bind svseq_top svseq_chk #(.OFF_W(OFF_W), .SV_W(SV_W), .STATE_W(STATE_W), .EL_W(EL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .busy(busy),
    .el_valid(el_valid), .el_wen(el_wen), .el_zwr(el_zwr),
    .src_el(src_el), .dst_el(dst_el), .done(done), .trap_out(trap_out)
);

// File: tb/svseq_top_tb_top.sv
module svseq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] state_q;
    logic        start = 1'b0;
    logic [63:0] pred_mask = '0;
    logic        zeroing = 1'b0, ffirst = 1'b0, ff_test = 1'b0;
    logic        res_trap = 1'b0, res_zero = 1'b0;
    logic        busy, el_valid, el_wen, el_zwr, done, trap_out, cut;
    logic [7:0]  src_el, dst_el;
    logic [6:0]  done_len;

    always #4 clk = ~clk;

    svseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .state_q(state_q), .start(start), .pred_mask(pred_mask),
        .zeroing(zeroing), .ffirst(ffirst), .ff_test(ff_test),
        .res_trap(res_trap), .res_zero(res_zero), .busy(busy),
        .el_valid(el_valid), .el_wen(el_wen), .el_zwr(el_zwr),
        .src_el(src_el), .dst_el(dst_el), .done(done), .trap_out(trap_out),
        .cut(cut), .done_len(done_len)
    );

    int n_chk = 0, n_bad = 0;

    int e_idx[256]; bit e_wen[256]; int e_n, e_kind, e_len; bit e_cut;
    int o_idx[256]; bit o_wen[256]; bit o_zwr[256]; bit o_dok[256];
    int o_n, o_kind, o_len, o_cyc; bit o_cut; logic [31:0] o_state;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int mx, input int vl, input int sv,
                                       input int i, input int s);
        return {2'b00, 2'(s), 2'(s), 2'(sv), 6'(i), 6'(i), 6'(vl), 6'(mx)};
    endfunction

    task automatic cfg(input logic [31:0] w);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = w;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    // Reference loop built from the requirements
    task automatic model(input int vl_n, input int sv_n, input logic [63:0] mask,
                         input bit zer, input bit ff, input bit tst,
                         input int trap_at, input int zero_at, input int i0, input int s0);
        e_n = 0; e_kind = 0; e_len = vl_n; e_cut = 1'b0;
        for (int i = i0; i < vl_n; i++) begin
            if (!mask[i] && !zer) continue;
            for (int s = (i == i0) ? s0 : 0; s < sv_n; s++) begin
                e_idx[e_n] = i * sv_n + s; e_wen[e_n] = mask[i]; e_n++;
                if (mask[i] && (i * sv_n + s) == trap_at) begin
                    if (ff && i != 0) begin e_cut = 1'b1; e_len = i; end
                    else e_kind = 1;
                    return;
                end
                if (mask[i] && ff && tst && (i * sv_n + s) == zero_at) begin
                    e_cut = 1'b1; e_len = i; return;
                end
            end
        end
    endtask

    task automatic run_op(input logic [63:0] mask, input bit zer, input bit ff,
                          input bit tst, input int trap_at, input int zero_at, input bit poke);
        @(negedge clk);
        start = 1'b1; pred_mask = mask; zeroing = zer; ffirst = ff; ff_test = tst;
        @(negedge clk);
        start = 1'b0;
        o_n = 0; o_cyc = 0; o_kind = -1; o_len = -1; o_cut = 1'b0;
        for (int c = 0; c < 1000; c++) begin
            if (poke && c == 0) begin cfg_wr = 1'b1; cfg_wdata = mk(2, 1, 0, 0, 0); end
            else cfg_wr = 1'b0;
            if (done) begin o_kind = 0; o_len = done_len; o_cut = cut; break; end
            if (trap_out) begin o_kind = 1; break; end
            o_cyc++;
            if (el_valid && o_n < 256) begin
                o_idx[o_n] = src_el; o_wen[o_n] = el_wen; o_zwr[o_n] = el_zwr;
                o_dok[o_n] = (dst_el == src_el); o_n++;
            end
            res_trap = el_wen && (int'(src_el) == trap_at);
            res_zero = el_wen && (int'(src_el) == zero_at);
            @(negedge clk);
        end
        cfg_wr = 1'b0; res_trap = 1'b0; res_zero = 1'b0;
        o_state = state_q;
    endtask

    task automatic verify(input string tag);
        chk(o_n == e_n, tag, "element count", o_n, e_n);
        for (int k = 0; k < e_n && k < o_n; k++) begin
            chk(o_idx[k] == e_idx[k], tag, "element index", o_idx[k], e_idx[k]);
            chk(o_wen[k] == e_wen[k], tag, "write strobe", o_wen[k], e_wen[k]);
            chk(o_zwr[k] == !e_wen[k], tag, "zero strobe", o_zwr[k], !e_wen[k]);
            chk(o_dok[k], tag, "R3 dst_el equals src_el", 0, 1);
        end
        chk(o_kind == e_kind, tag, "end kind (0 done,1 trap)", o_kind, e_kind);
        if (e_kind == 0) begin
            chk(o_len == e_len, tag, "done_len", o_len, e_len);
            chk(o_cut == e_cut, tag, "cut", o_cut, e_cut);
        end
    endtask

    localparam logic [31:0] BASE = 32'h0100_00C7; // maxlen 8, length 4, group 2

    task automatic t_reset();
        chk(state_q == 32'h0000_003F, "R1", "reset state", state_q, 32'h3F);
        chk({busy, el_valid, done, trap_out} == 4'b0, "R1", "reset outputs",
            {busy, el_valid, done, trap_out}, 0);
    endtask

    task automatic t_cfg();
        cfg({2'b10, 2'b01, 2'b01, 6'd5, 6'd3, 6'd20, 6'd7});
        chk(state_q == mk(7, 7, 1, 3, 1), "R2", "clamped config word", state_q, mk(7, 7, 1, 3, 1));
        cfg(BASE);
        chk(state_q == mk(7, 3, 1, 0, 0), "R2", "base config word", state_q, mk(7, 3, 1, 0, 0));
    endtask

    task automatic t_plain();
        model(4, 2, 64'hF, 0, 0, 0, -1, -1, 0, 0);
        run_op(64'hF, 0, 0, 0, -1, -1, 0);
        verify("R3/R4/R7 plain");
        chk(o_state == BASE, "R7", "state after done", o_state, BASE);
    endtask

    task automatic t_zeroing();
        model(4, 2, 64'h5, 1, 0, 0, -1, -1, 0, 0);
        run_op(64'h5, 1, 0, 0, -1, -1, 0);
        verify("R5 zeroing");
    endtask

    task automatic t_skip();
        model(4, 2, 64'h5, 0, 0, 0, -1, -1, 0, 0);
        run_op(64'h5, 0, 0, 0, -1, -1, 0);
        verify("R6 skip");
        chk(o_cyc == 6, "R6", "run cycles with two skipped groups", o_cyc, 6);
    endtask

    task automatic t_fftrap();
        model(4, 2, 64'hF, 0, 1, 0, 5, -1, 0, 0);
        run_op(64'hF, 0, 1, 0, 5, -1, 0);
        verify("R9 ff trap");
        chk(o_state == mk(7, 1, 1, 0, 0), "R9", "shortened length word", o_state, mk(7, 1, 1, 0, 0));
        cfg(BASE);
    endtask

    task automatic t_trap_resume();
        model(4, 2, 64'hF, 0, 0, 0, 5, -1, 0, 0);
        run_op(64'hF, 0, 0, 0, 5, -1, 0);
        verify("R8 trap");
        chk(o_state == mk(7, 3, 1, 2, 1), "R8", "saved offsets", o_state, mk(7, 3, 1, 2, 1));
        model(4, 2, 64'hF, 0, 0, 0, -1, -1, 2, 1);
        run_op(64'hF, 0, 0, 0, -1, -1, 0);
        verify("R8 resume");
        model(4, 2, 64'hF, 0, 1, 0, 1, -1, 0, 0);
        run_op(64'hF, 0, 1, 0, 1, -1, 0);
        verify("R8 ff trap in group 0");
        chk(o_state == mk(7, 3, 1, 0, 1), "R8", "saved offsets group 0", o_state, mk(7, 3, 1, 0, 1));
        model(4, 2, 64'hF, 0, 1, 0, -1, -1, 0, 1);
        run_op(64'hF, 0, 1, 0, -1, -1, 0);
        verify("R8 resume group 0");
    endtask

    task automatic t_fftest();
        model(4, 2, 64'hD, 0, 1, 1, -1, 6, 0, 0);
        run_op(64'hD, 0, 1, 1, -1, 6, 0);
        verify("R10/R11 ff test");
        chk(o_state == mk(7, 2, 1, 0, 0), "R11", "length counts masked group", o_state, mk(7, 2, 1, 0, 0));
        cfg(BASE);
        model(4, 2, 64'hF, 0, 1, 1, -1, 0, 0, 0);
        run_op(64'hF, 0, 1, 1, -1, 0, 0);
        verify("R10 zero in group 0");
        chk(o_state == mk(7, 0, 1, 0, 0), "R10", "length code floor", o_state, mk(7, 0, 1, 0, 0));
        cfg(BASE);
    endtask

    task automatic t_busy_cfg();
        model(4, 2, 64'hF, 0, 0, 0, -1, -1, 0, 0);
        run_op(64'hF, 0, 0, 0, -1, -1, 1);
        verify("R2 busy write");
        chk(o_state == BASE, "R2", "write while busy ignored", o_state, BASE);
        chk(o_state[11:6] <= o_state[5:0], "R12", "length within maxlen", o_state[11:6], o_state[5:0]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_plain();
        t_zeroing();
        t_skip();
        t_fftrap();
        t_trap_resume();
        t_fftest();
        t_busy_cfg();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule